// File: doc/BRIEF.md
# Upset-Tolerant Handshake Sequencer

This block is a small control sequencer whose state register is built to ride through single-event upsets. Three copies of the state code are kept. A per-bit two-of-three vote picks the working code, and every clock edge loads all three copies from the next state computed from that vote. A flipped copy is therefore overwritten one cycle after it goes wrong, and errors cannot pile up.

The legal state codes are six bits wide and lie at least three bit flips apart. A voted code that is one flip away from a legal code is read as that state, so the machine carries on where it was. A voted code that is two or more flips from every legal code is taken as lost. The machine then returns to idle and flags the event for that cycle. The example sequence is a request/acknowledge handshake followed by a fixed-length transfer phase. Fault-injection inputs let a test flip any bit of any copy for one clock. In normal use they are tied to zero.

Top module: `tmr_seq_fsm`

## Requirements
- R1: In the cycle after a synchronous active-low reset is released, `state_o` is 0 (idle) and `xfer_o`, `done_o`, `fix_o` and `unc_o` are all low.
- R2: From idle, a cycle with `req_i` high moves the machine to the request state (`state_o`=1) at the next edge. In idle with `req_i` low, the machine stays in idle.
- R3: The request state moves to the wait state (`state_o`=2) one cycle later. The wait state holds for as long as `ack_i` is low and moves to the transfer state (`state_o`=3) at the edge after `ack_i` is high.
- R4: The transfer state lasts exactly `XFER_CYCLES` cycles with `xfer_o` high. It is followed by exactly one done cycle (`state_o`=4, `done_o` high) and then idle.
- R5: Bit `c*6+b` of `inj_i` flips bit b of copy c at the next edge. A single such flip, in any copy, any bit and any state, leaves the `state_o` sequence unchanged. It raises `fix_o` for the one cycle after the flip.
- R6: Every copy is reloaded from the voted result at each edge. In the cycle after an edge with `inj_i` zero, `fix_o` is low. Flips in two different copies on consecutive cycles still leave the sequence unchanged.
- R7: The legal codes are idle 000000, request 000111, wait 111000, transfer 011011 and done 101101, with every pair at least 3 apart. If the same bit is flipped in two copies, the voted code is one flip from the true state. It is decoded as that state, the sequence is unchanged, `fix_o` pulses and `unc_o` stays low.
- R8: If the voted code is two or more flips from every legal code, `unc_o` and `fix_o` are high, `state_o` reads idle in that cycle, and the machine is in idle at the next edge.
- R9: The visible state only changes along the defined transitions (idle to request, request to wait, wait to transfer, transfer to done, done to idle) or to idle after an uncorrectable code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Start request, sampled in idle |
| ack_i | input | 1 | Acknowledge, sampled in the wait state |
| inj_i | input | 18 | Test-only flip mask, copy c bit b at index c*6+b |
| state_o | output | 3 | Decoded state: 0 idle, 1 request, 2 wait, 3 transfer, 4 done |
| xfer_o | output | 1 | High in the transfer state |
| done_o | output | 1 | High in the done cycle |
| fix_o | output | 1 | Copies disagree or voted code is not legal |
| unc_o | output | 1 | Voted code is not within one flip of any legal code |

## Verification
The bench flips every bit of every copy, one at a time, at points spread across all five states. A voter that picks the wrong majority, or a copy that is never reloaded, would change the state trace or leave `fix_o` high for more than one cycle. The same bit is flipped in two copies to reach the nearest-code decoder: a decoder that rejected distance-one codes would drop to idle instead of keeping the transfer running. A two-bit corruption made in the wait state must force idle with `unc_o`. A design that decoded that code as a neighbouring state would enter transfer when the later acknowledge arrives.

// File: rtl/tmr_fsm_pkg.sv
// Package: state codes and types shared by the upset-tolerant sequencer.
// Assumes the code width of 6 is enough for five codes that are pairwise
// at least three flips apart; the codes below meet that.
package tmr_fsm_pkg;

    localparam int SW     = 6;   // width of one state code copy
    localparam int NUM_ST = 5;   // number of legal states
    localparam int NCOPY  = 3;   // redundant copies

    typedef logic [SW-1:0] code_t;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_REQ  = 3'd1,
        S_WAIT = 3'd2,
        S_XFER = 3'd3,
        S_DONE = 3'd4
    } st_e;

    localparam code_t C_IDLE = 6'b000000;
    localparam code_t C_REQ  = 6'b000111;
    localparam code_t C_WAIT = 6'b111000;
    localparam code_t C_XFER = 6'b011011;
    localparam code_t C_DONE = 6'b101101;

    // Map a state to its stored code.
    function automatic code_t st_code(input st_e s);
        case (s)
            S_REQ:   return C_REQ;
            S_WAIT:  return C_WAIT;
            S_XFER:  return C_XFER;
            S_DONE:  return C_DONE;
            default: return C_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/tmr_voter.sv
// Bitwise two-of-three voter. Also reports whether any copy disagrees.
// Assumes copies arrive straight from registers (no further timing).
module tmr_voter #(
    parameter int W = 6
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] voted_o,
    output logic         mismatch_o
);

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            // majority of the three copies for this bit
            assign voted_o[g] = (a_i[g] & b_i[g]) | (a_i[g] & c_i[g]) | (b_i[g] & c_i[g]);
        end
    endgenerate

    // any disagreement between copies
    assign mismatch_o = (a_i != b_i) || (a_i != c_i);

endmodule

// File: rtl/tmr_code_decoder.sv
// Nearest-legal-code decoder. A code within one flip of a legal code maps
// to that state; anything farther from all codes gives idle plus unc_o.
// Assumes legal codes are pairwise at least 3 apart, so matches are unique.
module tmr_code_decoder
    import tmr_fsm_pkg::*;
(
    input  code_t code_i,
    output st_e   state_o,
    output logic  legal_o,
    output logic  unc_o
);

    // search every legal code for an exact or one-flip match
    always_comb begin
        int d;
        legal_o = 1'b0;
        unc_o   = 1'b1;
        state_o = S_IDLE;
        d       = 0;
        for (int i = 0; i < NUM_ST; i++) begin
            d = $countones(code_i ^ st_code(st_e'(i)));
            if (d == 0) legal_o = 1'b1;
            if (d <= 1) begin
                unc_o   = 1'b0;
                state_o = st_e'(i);
            end
        end
    end

endmodule

// File: rtl/tmr_seq_next.sv
// Next-state logic of the handshake sequence: idle, request, wait for
// acknowledge, transfer for XFER_CYCLES, done, idle. Assumes the state
// given in is already decoded; an uncorrectable code forces idle.
module tmr_seq_next
    import tmr_fsm_pkg::*;
#(
    parameter int XFER_CYCLES = 4,
    parameter int CW          = 3
) (
    input  st_e           st_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          unc_i,
    input  logic          req_i,
    input  logic          ack_i,
    output st_e           st_o,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] LAST = CW'(XFER_CYCLES - 1);

    // transition table plus transfer-length counter
    always_comb begin
        st_o  = st_i;
        cnt_o = '0;
        if (unc_i) begin
            st_o = S_IDLE;
        end else begin
            case (st_i)
                S_IDLE: if (req_i) st_o = S_REQ;
                S_REQ:  st_o = S_WAIT;
                S_WAIT: if (ack_i) st_o = S_XFER;
                S_XFER: begin
                    if (cnt_i == LAST) st_o = S_DONE;
                    else               cnt_o = cnt_i + 1'b1;
                end
                S_DONE: st_o = S_IDLE;
                default: st_o = S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tmr_seq_fsm.sv
// Top: triplicated state register with vote, nearest-code decode and
// write-back of the next state into all copies every cycle. inj_i flips
// chosen bits of chosen copies at the edge; tie to zero outside test.
// Assumes reset is held for at least one clock edge.
module tmr_seq_fsm
    import tmr_fsm_pkg::*;
#(
    parameter int XFER_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic                ack_i,
    input  logic [NCOPY*SW-1:0] inj_i,
    output logic [2:0]          state_o,
    output logic                xfer_o,
    output logic                done_o,
    output logic                fix_o,
    output logic                unc_o
);

    localparam int CW = $clog2(XFER_CYCLES + 1);

    code_t         copy_q [NCOPY];
    code_t         voted;
    logic          mismatch;
    st_e           cur_st;
    st_e           nxt_st;
    logic          legal;
    logic          unc;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    tmr_voter #(.W(SW)) u_vote (
        .a_i        (copy_q[0]),
        .b_i        (copy_q[1]),
        .c_i        (copy_q[2]),
        .voted_o    (voted),
        .mismatch_o (mismatch)
    );

    tmr_code_decoder u_dec (
        .code_i  (voted),
        .state_o (cur_st),
        .legal_o (legal),
        .unc_o   (unc)
    );

    tmr_seq_next #(.XFER_CYCLES(XFER_CYCLES), .CW(CW)) u_next (
        .st_i  (cur_st),
        .cnt_i (cnt_q),
        .unc_i (unc),
        .req_i (req_i),
        .ack_i (ack_i),
        .st_o  (nxt_st),
        .cnt_o (cnt_d)
    );

    genvar g;
    generate
        for (g = 0; g < NCOPY; g++) begin : g_copy
            // each copy reloads the voted next state, with optional test flip
            always_ff @(posedge clk) begin
                if (!rst_n) copy_q[g] <= C_IDLE;
                else        copy_q[g] <= st_code(nxt_st) ^ inj_i[g*SW +: SW];
            end
        end
    endgenerate

    // transfer-length counter
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign state_o = cur_st;
    assign xfer_o  = (cur_st == S_XFER);
    assign done_o  = (cur_st == S_DONE);
    assign fix_o   = mismatch | ~legal;
    assign unc_o   = unc;

    logic inj_any;
    assign inj_any = |inj_i;

    p_req_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == S_IDLE && req_i && !unc && !inj_any) |=> (cur_st == S_REQ));

    p_req_to_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == S_REQ && !inj_any) |=> (cur_st == S_WAIT));

    p_done_to_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == S_DONE && !inj_any) |=> (cur_st == S_IDLE));

    p_fix_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !inj_any |=> !fix_o);

    p_unc_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (unc && !inj_any) |=> (cur_st == S_IDLE));

    p_legal_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st != $past(cur_st)) |->
            (cur_st == S_IDLE) ||
            ($past(cur_st) == S_IDLE && cur_st == S_REQ) ||
            ($past(cur_st) == S_REQ  && cur_st == S_WAIT) ||
            ($past(cur_st) == S_WAIT && cur_st == S_XFER) ||
            ($past(cur_st) == S_XFER && cur_st == S_DONE));

endmodule

// File: tb/sim_tmr_seq_fsm.sv
module sim_tmr_seq_fsm;

    localparam int N    = 4;
    localparam int LEN  = 16;
    localparam int MW   = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic          ack_i = 1'b0;
    logic [MW-1:0] inj_i = '0;
    logic [2:0]    state_o;
    logic          xfer_o, done_o, fix_o, unc_o;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    tmr_seq_fsm #(.XFER_CYCLES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i), .inj_i(inj_i),
        .state_o(state_o), .xfer_o(xfer_o), .done_o(done_o),
        .fix_o(fix_o), .unc_o(unc_o)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_bad++;
                $display("FAIL watchdog: run hung, act=%0d exp<%0d", cycles, 100000);
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d at t=%0t", rq, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_i = 1'b0; ack_i = 1'b0; inj_i = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // reset state (R1)
    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(state_o == 3'd0, "R1 state", state_o, 0);
        chk({xfer_o, done_o, fix_o, unc_o} == 4'b0, "R1 flags", {xfer_o, done_o, fix_o, unc_o}, 0);
    endtask

    // Fixed stimulus: req in cycle 1, ack in cycle 5; up to two injections.
    // Trace is checked against a reference model built from R2-R4.
    task automatic run_trace(input string rq, input int c1, input logic [MW-1:0] m1,
                             input int c2, input logic [MW-1:0] m2, input bit unc_exp);
        int mst = 0;
        int mcnt = 0;
        bit efix, eunc;
        do_reset();
        for (int s = 0; s < LEN; s++) begin
            if (unc_exp && s == c1 + 1) begin
                mst = 0; mcnt = 0;
            end
            efix = (s - 1 == c1 && m1 != '0) || (s - 1 == c2 && m2 != '0);
            eunc = unc_exp && (s == c1 + 1);
            chk(state_o == 3'(mst), rq, state_o, mst);
            chk(xfer_o == (mst == 3), {rq, " R4 xfer_o"}, xfer_o, (mst == 3));
            chk(done_o == (mst == 4), {rq, " R4 done_o"}, done_o, (mst == 4));
            chk(fix_o == efix, {rq, " fix_o"}, fix_o, efix);
            chk(unc_o == eunc, {rq, " R8 unc_o"}, unc_o, eunc);
            req_i = (s == 1);
            ack_i = (s == 5);
            inj_i = (s == c1) ? m1 : ((s == c2) ? m2 : '0);
            case (mst)
                0: if (req_i) mst = 1;
                1: mst = 2;
                2: if (ack_i) begin mst = 3; mcnt = 0; end
                3: if (mcnt == N - 1) mst = 4; else mcnt++;
                default: mst = 0;
            endcase
            @(negedge clk);
        end
        inj_i = '0; req_i = 1'b0; ack_i = 1'b0;
    endtask

    // fault-free handshake, wait holding, transfer length (R2 R3 R4 R9)
    task automatic t_plain();
        run_trace("R2 R3 R4 R9 plain", -9, '0, -9, '0, 1'b0);
    endtask

    // every single bit of every copy (R5)
    task automatic t_single();
        for (int c = 0; c < 3; c++) begin
            for (int b = 0; b < 6; b++) begin
                logic [MW-1:0] m;
                m = '0;
                m[c*6 + b] = 1'b1;
                run_trace("R5 single flip", 1 + (c * 6 + b) % 11, m, -9, '0, 1'b0);
            end
        end
    endtask

    // flips in two copies on consecutive cycles (R6)
    task automatic t_writeback();
        logic [MW-1:0] ma, mb;
        ma = '0; mb = '0;
        ma[0*6 + 2] = 1'b1;
        mb[1*6 + 4] = 1'b1;
        run_trace("R6 consecutive", 6, ma, 7, mb, 1'b0);
        ma = '0; mb = '0;
        ma[2*6 + 1] = 1'b1;
        mb[0*6 + 1] = 1'b1;
        run_trace("R6 same bit later", 3, ma, 4, mb, 1'b0);
    endtask

    // same bit in two copies -> one-flip voted code (R7)
    task automatic t_double_copy();
        for (int b = 0; b < 6; b++) begin
            logic [MW-1:0] m;
            m = '0;
            m[0*6 + b] = 1'b1;
            m[1*6 + b] = 1'b1;
            run_trace("R7 two copies", 7, m, -9, '0, 1'b0);
        end
    endtask

    // two-bit voted corruption in wait state -> idle (R8): wait 111000 becomes 110001
    task automatic t_uncorrectable();
        logic [MW-1:0] m;
        m = '0;
        m[0*6 + 0] = 1'b1; m[0*6 + 3] = 1'b1;
        m[1*6 + 0] = 1'b1; m[1*6 + 3] = 1'b1;
        run_trace("R8 uncorrectable", 3, m, -9, '0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_single();
        t_writeback();
        t_double_copy();
        t_uncorrectable();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule